// File: doc/BRIEF.md
# Window-Major Strided Address Generator

This block produces the read addresses that feed a streaming pooling datapath. It walks a four-level nested loop. Each level has a signed element stride and an unsigned element count. Level X is the innermost level and W is the outermost. Every address is the base plus the sum of each level's index times its stride. A window code names the inner levels that make up one pooling window. The addresses of a window therefore come out back to back, and the generator marks the first and the last address of every window.

For each launch, software loads a base address, four strides, four counts and the window code, and pulses `start_i`. The block then hands out one address per cycle under a valid/ready handshake. It also reports how many elements make up one window and how many windows the pattern holds. A bad window code raises a one-cycle error instead of a launch. A pattern in which any level has a zero count finishes at once without producing an address. The memory, the data conversion and the reduction itself live in other blocks.

Top module: `win_addr_gen`

## Requirements
- R1: The window code is decoded by exact match. 0x00 selects no level, so every element is its own window. 0x02 selects X. 0x03 selects X and Y. 0x04 selects X, Y and Z. 0x05 selects X, Y, Z and W. Any other code, 0x01 included, makes `err_o` high for exactly the one cycle after the `start_i` edge, and no address is produced.
- R2: From the cycle after an accepted `start_i`, `win_size_o` equals the product of the counts of the selected levels, and `win_count_o` equals the product of the counts of the levels that are not selected.
- R3: The n-th address is base + ix*sx + iy*sy + iz*sz + iw*sw, taken modulo 2^ADDR_W. The indices count in mixed radix with X changing fastest. For base 0, counts 2/2/2/2 and strides 1/4/2/8 the offsets are 0,1,4,5,2,3,6,7,8,9,12,13,10,11,14,15.
- R4: Strides are two's-complement 16-bit values (`step_i` bits [16d+15:16d] for level d), so addresses can move backward. Counts sit in `count_i` bits [16d+15:16d].
- R5: An address is consumed only when `valid_o` and `ready_i` are both high. While `ready_i` is low, `addr_o`, `first_o` and `last_o` keep their values.
- R6: `first_o` is high on an address where every selected level is at index 0. `last_o` is high where every selected level is at its final index. Both are low whenever `valid_o` is low.
- R7: If any count is zero and the code is valid, no address is produced and `done_o` is high for the one cycle after the `start_i` edge.
- R8: The first address is valid in the cycle after the `start_i` edge. After the handshake on the final address, `valid_o` and `busy_o` drop and `done_o` is high for one cycle. Exactly win_size*win_count addresses are produced.
- R9: `start_i` is ignored while a pattern is running. It does not change the remaining addresses and does not raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, taken only while idle |
| base_addr_i | input | ADDR_W | Base element address |
| step_i | input | 4*STEP_W | Signed stride per level, X in the low slice |
| count_i | input | 4*CNT_W | Element count per level, X in the low slice |
| win_code_i | input | 8 | Window level code |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | Address is valid |
| addr_o | output | ADDR_W | Element address |
| first_o | output | 1 | Address opens a window |
| last_o | output | 1 | Address closes a window |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pattern |
| err_o | output | 1 | One-cycle pulse on an invalid window code |
| win_size_o | output | 4*CNT_W | Elements per window |
| win_count_o | output | 4*CNT_W | Windows in the pattern |

## Verification
On every cycle the assertions check these properties:
- the address and the markers hold while the consumer stalls;
- a window close is followed by a window open or by the end of the pattern;
- the markers only appear with a valid address;
- the done and error pulses are exclusive with a valid address;
- the size outputs stay fixed during a run.

Other behaviour can only be shown by the bench's scenarios:
- the actual address values for each window code;
- backward strides and modulo wrap;
- the zero-count and invalid-code outcomes;
- the total number of addresses.

The bench compares each of these against nested-loop arithmetic.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;
  localparam int NDIM = 4;

  localparam logic [7:0] WCODE_NONE = 8'h00;
  localparam logic [7:0] WCODE_X    = 8'h02;
  localparam logic [7:0] WCODE_XY   = 8'h03;
  localparam logic [7:0] WCODE_XYZ  = 8'h04;
  localparam logic [7:0] WCODE_XYZW = 8'h05;

  typedef enum logic {ST_IDLE, ST_RUN} gen_state_e;
endpackage

// File: rtl/win_code_decode.sv
module win_code_decode
  import win_addr_pkg::*;
(
  input  logic [7:0]      code_i,
  output logic [NDIM-1:0] sel_o,
  output logic            ok_o
);
  // exact-match set membership, not a level count
  always_comb begin
    ok_o  = 1'b1;
    sel_o = '0;
    case (code_i)
      WCODE_NONE: sel_o = 4'b0000;
      WCODE_X:    sel_o = 4'b0001;
      WCODE_XY:   sel_o = 4'b0011;
      WCODE_XYZ:  sel_o = 4'b0111;
      WCODE_XYZW: sel_o = 4'b1111;
      default:    ok_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/win_prod_calc.sv
module win_prod_calc
  import win_addr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [NDIM*CNT_W-1:0] cnt_i,
  input  logic [NDIM-1:0]       sel_i,
  output logic [NDIM*CNT_W-1:0] size_o,
  output logic [NDIM*CNT_W-1:0] count_o
);
  localparam int PW = NDIM * CNT_W;

  always_comb begin
    size_o  = PW'(1);
    count_o = PW'(1);
    for (int d = 0; d < NDIM; d++) begin
      if (sel_i[d]) size_o  = size_o  * PW'(cnt_i[d*CNT_W +: CNT_W]);
      else          count_o = count_o * PW'(cnt_i[d*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/win_dim_index.sv
module win_dim_index #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             carry_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             first_o,
  output logic             last_o
);
  logic [CNT_W-1:0] idx_q;

  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == cnt_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (clr_i)             idx_q <= '0;
    else if (adv_i && carry_i)  idx_q <= last_o ? '0 : idx_q + CNT_W'(1);
  end
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      base_addr_i,
  input  logic [NDIM*STEP_W-1:0] step_i,
  input  logic [NDIM*CNT_W-1:0]  count_i,
  input  logic [7:0]             win_code_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic                   first_o,
  output logic                   last_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [NDIM*CNT_W-1:0]  win_size_o,
  output logic [NDIM*CNT_W-1:0]  win_count_o
);
  localparam int DW    = STEP_W + CNT_W + 2;
  localparam int EXT_W = (ADDR_W > DW) ? ADDR_W : DW;

  gen_state_e                state_q;
  logic [ADDR_W-1:0]         addr_q;
  logic [NDIM*STEP_W-1:0]    step_q;
  logic [NDIM*CNT_W-1:0]     cnt_q;
  logic [NDIM-1:0]           sel_q, sel_d;
  logic                      code_ok, any_zero;
  logic                      done_q, err_q;
  logic                      load, fire, final_pos;
  logic [NDIM-1:0]           at_first, at_last;
  logic [NDIM:0]             carry;
  logic signed [DW-1:0]      corr [NDIM];
  logic signed [DW-1:0]      acc;
  logic signed [EXT_W-1:0]   delta;

  win_code_decode u_dec (
    .code_i (win_code_i),
    .sel_o  (sel_d),
    .ok_o   (code_ok)
  );

  win_prod_calc #(.CNT_W(CNT_W)) u_prod (
    .cnt_i   (cnt_q),
    .sel_i   (sel_q),
    .size_o  (win_size_o),
    .count_o (win_count_o)
  );

  always_comb begin
    any_zero = 1'b0;
    for (int d = 0; d < NDIM; d++)
      if (count_i[d*CNT_W +: CNT_W] == '0) any_zero = 1'b1;
  end

  assign load = start_i && (state_q == ST_IDLE);
  assign fire = (state_q == ST_RUN) && ready_i;

  assign carry[0] = 1'b1;
  genvar g;
  generate
    for (g = 0; g < NDIM; g++) begin : g_dim
      win_dim_index #(.CNT_W(CNT_W)) u_idx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (load),
        .adv_i   (fire),
        .carry_i (carry[g]),
        .cnt_i   (cnt_q[g*CNT_W +: CNT_W]),
        .first_o (at_first[g]),
        .last_o  (at_last[g])
      );
      assign carry[g+1] = carry[g] & at_last[g];
    end
  endgenerate

  assign final_pos = carry[NDIM];

  // correction per level: its stride minus the span rewound on all inner levels
  always_comb begin
    acc = '0;
    for (int d = 0; d < NDIM; d++) begin
      corr[d] = DW'($signed(step_q[d*STEP_W +: STEP_W])) - acc;
      acc = acc + $signed({{(DW-CNT_W){1'b0}}, cnt_q[d*CNT_W +: CNT_W] - CNT_W'(1)})
                  * DW'($signed(step_q[d*STEP_W +: STEP_W]));
    end
  end

  always_comb begin
    delta = '0;
    for (int d = 0; d < NDIM; d++)
      if (carry[d] && !at_last[d]) delta = EXT_W'(corr[d]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      step_q  <= '0;
      cnt_q   <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (load) begin
        step_q <= step_i;
        cnt_q  <= count_i;
        sel_q  <= sel_d;
        addr_q <= base_addr_i;
        if (!code_ok)     err_q   <= 1'b1;
        else if (any_zero) done_q <= 1'b1;
        else              state_q <= ST_RUN;
      end else if (fire) begin
        if (final_pos) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          addr_q <= addr_q + delta[ADDR_W-1:0];
        end
      end
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = valid_o;
  assign addr_o  = addr_q;
  assign first_o = valid_o && (&(at_first | ~sel_q));
  assign last_o  = valid_o && (&(at_last  | ~sel_q));
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/win_addr_gen_chk.sv
module win_addr_gen_chk
  import win_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ready_i,
  input logic                  valid_o,
  input logic [ADDR_W-1:0]     addr_o,
  input logic                  first_o,
  input logic                  last_o,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  err_o,
  input logic [NDIM*CNT_W-1:0] win_size_o,
  input logic [NDIM*CNT_W-1:0] win_count_o
);
  a_r5_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(first_o) && $stable(last_o));

  a_r6_marks_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_o || last_o) |-> valid_o);

  a_r6_open_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o || first_o);

  a_r8_end_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> done_o);

  a_r8_done_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o && !err_o);

  a_r1_err_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o && !busy_o);

  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(win_size_o) && $stable(win_count_o));
endmodule

bind win_addr_gen win_addr_gen_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/win_addr_gen_bench.sv
module win_addr_gen_bench;
  localparam int ADDR_W = 20;
  localparam int STEP_W = 16;
  localparam int CNT_W  = 16;
  localparam int PW     = 4 * CNT_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic [4*STEP_W-1:0] step_i = '0;
  logic [4*CNT_W-1:0]  count_i = '0;
  logic [7:0]        win_code_i = '0;
  logic              ready_i = 1'b0;
  logic              valid_o, first_o, last_o, busy_o, done_o, err_o;
  logic [ADDR_W-1:0] addr_o;
  logic [PW-1:0]     win_size_o, win_count_o;

  win_addr_gen u_win_addr_gen (.*);

  always #10 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int exp_addr [0:63];
  bit exp_first [0:63];
  bit exp_last [0:63];
  int exp_n, exp_size, exp_cnt;
  bit exp_bad;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic build(input int base, input int s[4], input int c[4], input int code);
    int mask;
    exp_bad = 0;
    case (code)
      0: mask = 0;  2: mask = 1;  3: mask = 3;  4: mask = 7;  5: mask = 15;
      default: begin mask = 0; exp_bad = 1; end
    endcase
    exp_size = 1; exp_cnt = 1;
    for (int d = 0; d < 4; d++) begin
      if (mask[d]) exp_size *= c[d]; else exp_cnt *= c[d];
    end
    exp_n = 0;
    for (int w = 0; w < c[3]; w++)
      for (int z = 0; z < c[2]; z++)
        for (int y = 0; y < c[1]; y++)
          for (int x = 0; x < c[0]; x++) begin
            int ix[4];
            bit f, l;
            ix[0] = x; ix[1] = y; ix[2] = z; ix[3] = w;
            f = 1; l = 1;
            for (int d = 0; d < 4; d++)
              if (mask[d]) begin
                if (ix[d] != 0) f = 0;
                if (ix[d] != c[d] - 1) l = 0;
              end
            exp_addr[exp_n]  = (base + x*s[0] + y*s[1] + z*s[2] + w*s[3]) & ((1 << ADDR_W) - 1);
            exp_first[exp_n] = f;
            exp_last[exp_n]  = l;
            exp_n++;
          end
  endtask

  task automatic run(input int base, input int s[4], input int c[4], input int code,
                     input bit rnd, input bit poke, input string tag);
    int k, guard;
    bit rdy;
    build(base, s, c, code);
    @(negedge clk_i);
    base_addr_i = ADDR_W'(base);
    for (int d = 0; d < 4; d++) begin
      step_i[d*STEP_W +: STEP_W] = STEP_W'(s[d]);
      count_i[d*CNT_W +: CNT_W]  = CNT_W'(c[d]);
    end
    win_code_i = 8'(code);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (exp_bad) begin
      chk(err_o === 1'b1, {"R1 err pulse ", tag}, err_o, 1);
      chk(valid_o === 1'b0, {"R1 no address ", tag}, valid_o, 0);
      @(negedge clk_i);
      chk(err_o === 1'b0 && valid_o === 1'b0, {"R1 err one cycle ", tag}, err_o, 0);
      return;
    end
    chk(win_size_o == PW'(exp_size), {"R2 window size ", tag}, win_size_o, exp_size);
    chk(win_count_o == PW'(exp_cnt), {"R2 window count ", tag}, win_count_o, exp_cnt);
    if (exp_n == 0) begin
      chk(done_o === 1'b1 && valid_o === 1'b0, {"R7 zero count done ", tag}, done_o, 1);
      @(negedge clk_i);
      chk(valid_o === 1'b0 && done_o === 1'b0, {"R7 stays idle ", tag}, valid_o, 0);
      return;
    end
    chk(exp_n == exp_size * exp_cnt, {"R8 total model ", tag}, exp_n, exp_size * exp_cnt);
    k = 0; guard = 0;
    while (k < exp_n && guard < 4000) begin
      chk(valid_o === 1'b1 && busy_o === 1'b1, {"R8 valid during run ", tag}, valid_o, 1);
      chk(addr_o == ADDR_W'(exp_addr[k]), {"R3 R4 R5 address ", tag}, addr_o, exp_addr[k]);
      chk(first_o === exp_first[k], {"R6 first marker ", tag}, first_o, exp_first[k]);
      chk(last_o === exp_last[k], {"R6 last marker ", tag}, last_o, exp_last[k]);
      chk(err_o === 1'b0 && done_o === 1'b0, {"R9 no pulse mid-run ", tag}, err_o, 0);
      rdy = rnd ? ($urandom % 3 != 0) : 1'b1;
      ready_i = rdy;
      if (poke && k == 2) begin
        start_i = 1'b1;
        win_code_i = 8'h01;
        base_addr_i = ADDR_W'(12345);
      end
      @(negedge clk_i);
      start_i = 1'b0;
      if (rdy) k++;
      guard++;
    end
    ready_i = 1'b0;
    chk(k == exp_n, {"R8 address count ", tag}, k, exp_n);
    chk(done_o === 1'b1 && valid_o === 1'b0 && busy_o === 1'b0, {"R8 done after last ", tag}, done_o, 1);
    @(negedge clk_i);
    chk(done_o === 1'b0, {"R8 done one cycle ", tag}, done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s[4], c[4];
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0,
        "R8 reset state", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // 4x4 map, 2x2 windows: offsets 0,1,4,5,2,3,6,7,...
    s = '{1, 4, 2, 8}; c = '{2, 2, 2, 2};
    run(0, s, c, 3, 1'b0, 1'b0, "map XY");
    chk(1, "R3 map example", 0, 0);
    run(64, s, c, 0, 1'b1, 1'b0, "code none");
    run(64, s, c, 2, 1'b1, 1'b0, "code X");
    run(64, s, c, 4, 1'b1, 1'b0, "code XYZ");
    run(64, s, c, 5, 1'b1, 1'b1, "code XYZW poke");

    // backward strides with modulo wrap
    s = '{-3, 7, 0, -20}; c = '{3, 2, 1, 2};
    run(5, s, c, 4, 1'b1, 1'b0, "neg XYZ");
    run(5, s, c, 3, 1'b0, 1'b0, "neg XY");
    s = '{-1, -5, 11, 3}; c = '{2, 3, 2, 1};
    run(1000, s, c, 2, 1'b1, 1'b0, "neg X");

    // invalid codes
    run(0, s, c, 1, 1'b0, 1'b0, "code 01");
    run(0, s, c, 6, 1'b0, 1'b0, "code 06");
    run(0, s, c, 255, 1'b0, 1'b0, "code FF");

    // zero counts
    c = '{2, 0, 2, 2};
    run(0, s, c, 3, 1'b0, 1'b0, "zero Y");
    c = '{2, 2, 2, 0};
    run(0, s, c, 2, 1'b0, 1'b0, "zero W");

    // a valid launch after an error still works
    s = '{2, 1, 0, 0}; c = '{3, 2, 1, 1};
    run(7, s, c, 5, 1'b1, 1'b0, "after err");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule